// File: doc/BRIEF.md
# Readback Checker

The readback checker sits on the return path of a memory test engine. Each cycle in which the engine presents a read vector, the block compares the returned data against the expected pattern across nine byte lanes (eight data lanes and one ECC lane). A per-bit mask removes bits from the comparison. The block records what it finds in several ways: a sticky flag for every bit, a sticky flag for every lane, a saturating error counter for every lane and one for the whole bus, and the index of the first failing vector.

On the first failing vector the block can emit a one-cycle trigger pulse for a logic analyser. It can also raise a level request asking the test engine to halt. A sequence-start strobe returns all recorded state to zero, so the next test begins from a clean slate. Software or the test engine clears the bit flags, the lane flags and the first-error capture through separate strobes.

Top module: `readback_checker`

## Requirements
- R1: A data bit is compared only when its mask bit is 0; a mask bit of 1 never produces an error. Bit b of lane l sits at position l*LANE_W+b of the data, mask and bit-flag buses.
- R2: A bit flag sets on an unmasked mismatch of an accepted vector and stays set. Bit l of `bit_clr_i` clears the flags of lane l. When a clear and a new mismatch occur in the same cycle, the mismatch wins.
- R3: Bit l of `byte_err_o` is a sticky flag that sets when any unmasked bit of lane l mismatches. It is cleared only by `byte_clr_i` and is independent of the bit-flag clears. A new mismatch wins over a clear in the same cycle.
- R4: Each lane counter adds one for every accepted vector with an unmasked mismatch in that lane. It saturates at all ones (0xFFFF at the default CNT_W of 16).
- R5: The global counter adds one for every accepted vector with an unmasked mismatch in any lane, however many lanes fail. It saturates at all ones.
- R6: The first-error capture records the 0-based index of the failing vector, counted among the vectors accepted since the last sequence start. It holds that index until `first_clr_i` or a sequence start. If `first_clr_i` arrives together with a failing vector, that vector becomes the new capture.
- R7: `trig_o` pulses high for one cycle after a vector that is captured as a first error, provided `trig_en_i` was high with that vector.
- R8: `stop_req_o` sets after a failing vector accepted while `stop_en_i` is high, and stays high until a sequence start.
- R9: `seq_start_i` zeroes all flags, counters, the capture, the stop request and the vector index. A vector presented in the same cycle is ignored.
- R10: After reset all outputs are zero.
- R11: While `vld_i` is low, no flag, counter or capture changes because of the data inputs.
- R12: All results appear at the outputs in the cycle after the clock edge that samples the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_start_i | input | 1 | Start of a new test sequence, clears all state |
| vld_i | input | 1 | Read vector valid |
| rd_data_i | input | NUM_LANES*LANE_W | Returned read data |
| exp_data_i | input | NUM_LANES*LANE_W | Expected pattern data |
| mask_i | input | NUM_LANES*LANE_W | Compare mask, 1 = bit ignored |
| bit_clr_i | input | NUM_LANES | Per-lane clear of the bit flags |
| byte_clr_i | input | 1 | Clear of all lane flags |
| first_clr_i | input | 1 | Release of the first-error capture |
| stop_en_i | input | 1 | Allow a stop request on error |
| trig_en_i | input | 1 | Allow the first-error trigger pulse |
| bit_err_o | output | NUM_LANES*LANE_W | Sticky per-bit error flags |
| byte_err_o | output | NUM_LANES | Sticky per-lane error flags |
| lane_cnt_o | output | NUM_LANES*CNT_W | Per-lane error counters, lane l at l*CNT_W |
| glob_cnt_o | output | CNT_W | Global error counter |
| first_vld_o | output | 1 | A first error is captured |
| first_idx_o | output | IDX_W | Index of the captured vector |
| trig_o | output | 1 | First-error trigger pulse |
| stop_req_o | output | 1 | Request to halt the sequence |

## Verification
The bench keeps the default nine lanes of eight bits and a 16-bit vector index, but builds the counters with CNT_W set to 4. This lets saturation of both a lane counter and the global counter be reached within twenty failing vectors, while the 0xFFFF case follows from the same parameterised logic. With the full lane count, the ECC lane and a mask on its top bit can be exercised next to the data lanes. The same holds for the set-over-clear race, the capture released and retaken in one cycle, and a failing vector that arrives together with a sequence start.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int unsigned RBC_LANES = 9;
  localparam int unsigned RBC_LANE_W = 8;
  localparam int unsigned RBC_CNT_W = 16;
  localparam int unsigned RBC_IDX_W = 16;
endpackage

// File: rtl/rbc_satcnt.sv
module rbc_satcnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rbc_lane.sv
module rbc_lane #(
  parameter int unsigned LW    = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seq_clr_i,
  input  logic             vld_i,
  input  logic [LW-1:0]    rd_i,
  input  logic [LW-1:0]    exp_i,
  input  logic [LW-1:0]    mask_i,
  input  logic             bit_clr_i,
  input  logic             byte_clr_i,
  output logic             err_o,
  output logic [LW-1:0]    bits_o,
  output logic             byte_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [LW-1:0] mis;

  // accepted-vector mismatch, masked bits removed
  assign mis   = vld_i ? ((rd_i ^ exp_i) & ~mask_i) : '0;
  assign err_o = |mis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_o <= '0;
      byte_o <= 1'b0;
    end else if (seq_clr_i) begin
      bits_o <= '0;
      byte_o <= 1'b0;
    end else begin
      bits_o <= (bit_clr_i ? '0 : bits_o) | mis;
      byte_o <= (byte_clr_i ? 1'b0 : byte_o) | err_o;
    end
  end

  rbc_satcnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (seq_clr_i),
    .inc_i  (err_o),
    .cnt_o  (cnt_o)
  );
endmodule

// File: rtl/rbc_first.sv
module rbc_first #(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seq_clr_i,
  input  logic             vld_i,
  input  logic             err_i,
  input  logic             first_clr_i,
  input  logic             trig_en_i,
  input  logic             stop_en_i,
  output logic             first_vld_o,
  output logic [IDX_W-1:0] first_idx_o,
  output logic             trig_o,
  output logic             stop_o
);
  logic [IDX_W-1:0] idx_q;
  logic             hold, hit;

  assign hold = first_vld_o & ~first_clr_i;
  assign hit  = vld_i & err_i & ~hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      first_vld_o <= 1'b0;
      first_idx_o <= '0;
      trig_o      <= 1'b0;
      stop_o      <= 1'b0;
    end else if (seq_clr_i) begin
      idx_q       <= '0;
      first_vld_o <= 1'b0;
      first_idx_o <= '0;
      trig_o      <= 1'b0;
      stop_o      <= 1'b0;
    end else begin
      if (vld_i) idx_q <= idx_q + 1'b1;
      first_vld_o <= hold | hit;
      if (hit)        first_idx_o <= idx_q;
      else if (!hold) first_idx_o <= '0;
      trig_o <= hit & trig_en_i;
      stop_o <= stop_o | (vld_i & err_i & stop_en_i);
    end
  end
endmodule

// File: rtl/readback_checker.sv
module readback_checker
  import rbc_pkg::*;
#(
  parameter int unsigned NUM_LANES = RBC_LANES,
  parameter int unsigned LANE_W    = RBC_LANE_W,
  parameter int unsigned CNT_W     = RBC_CNT_W,
  parameter int unsigned IDX_W     = RBC_IDX_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          seq_start_i,
  input  logic                          vld_i,
  input  logic [NUM_LANES*LANE_W-1:0]   rd_data_i,
  input  logic [NUM_LANES*LANE_W-1:0]   exp_data_i,
  input  logic [NUM_LANES*LANE_W-1:0]   mask_i,
  input  logic [NUM_LANES-1:0]          bit_clr_i,
  input  logic                          byte_clr_i,
  input  logic                          first_clr_i,
  input  logic                          stop_en_i,
  input  logic                          trig_en_i,
  output logic [NUM_LANES*LANE_W-1:0]   bit_err_o,
  output logic [NUM_LANES-1:0]          byte_err_o,
  output logic [NUM_LANES*CNT_W-1:0]    lane_cnt_o,
  output logic [CNT_W-1:0]              glob_cnt_o,
  output logic                          first_vld_o,
  output logic [IDX_W-1:0]              first_idx_o,
  output logic                          trig_o,
  output logic                          stop_req_o
);
  logic                 vld_acc;
  logic [NUM_LANES-1:0] lane_err;
  logic                 any_err;

  // a vector arriving with sequence start is dropped
  assign vld_acc = vld_i & ~seq_start_i;
  assign any_err = |lane_err;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    rbc_lane #(.LW(LANE_W), .CNT_W(CNT_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .seq_clr_i  (seq_start_i),
      .vld_i      (vld_acc),
      .rd_i       (rd_data_i[l*LANE_W +: LANE_W]),
      .exp_i      (exp_data_i[l*LANE_W +: LANE_W]),
      .mask_i     (mask_i[l*LANE_W +: LANE_W]),
      .bit_clr_i  (bit_clr_i[l]),
      .byte_clr_i (byte_clr_i),
      .err_o      (lane_err[l]),
      .bits_o     (bit_err_o[l*LANE_W +: LANE_W]),
      .byte_o     (byte_err_o[l]),
      .cnt_o      (lane_cnt_o[l*CNT_W +: CNT_W])
    );
  end

  rbc_satcnt #(.W(CNT_W)) u_glob (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (seq_start_i),
    .inc_i  (any_err),
    .cnt_o  (glob_cnt_o)
  );

  rbc_first #(.IDX_W(IDX_W)) u_first (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .seq_clr_i   (seq_start_i),
    .vld_i       (vld_acc),
    .err_i       (any_err),
    .first_clr_i (first_clr_i),
    .trig_en_i   (trig_en_i),
    .stop_en_i   (stop_en_i),
    .first_vld_o (first_vld_o),
    .first_idx_o (first_idx_o),
    .trig_o      (trig_o),
    .stop_o      (stop_req_o)
  );
endmodule

// File: rtl/rbc_chk.sv
module rbc_chk #(
  parameter int unsigned NUM_LANES = 9,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned IDX_W     = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        seq_start_i,
  input logic                        vld_i,
  input logic [NUM_LANES*LANE_W-1:0] mask_i,
  input logic [NUM_LANES-1:0]        bit_clr_i,
  input logic                        byte_clr_i,
  input logic                        first_clr_i,
  input logic                        stop_en_i,
  input logic [NUM_LANES*LANE_W-1:0] bit_err_o,
  input logic [NUM_LANES-1:0]        byte_err_o,
  input logic [NUM_LANES*CNT_W-1:0]  lane_cnt_o,
  input logic [CNT_W-1:0]            glob_cnt_o,
  input logic                        first_vld_o,
  input logic [IDX_W-1:0]            first_idx_o,
  input logic                        trig_o,
  input logic                        stop_req_o
);
  assert_mask_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> ((bit_err_o & ~$past(bit_err_o) & $past(mask_i)) == '0));

  assert_bits_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seq_start_i && bit_clr_i == '0) |=> ((bit_err_o & $past(bit_err_o)) == $past(bit_err_o)));

  assert_bytes_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seq_start_i && !byte_clr_i) |=> ((byte_err_o & $past(byte_err_o)) == $past(byte_err_o)));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assert_glob_ge_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      glob_cnt_o >= lane_cnt_o[l*CNT_W +: CNT_W]);
  end

  assert_glob_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_start_i |=> (glob_cnt_o == $past(glob_cnt_o)) ||
                     ({1'b0, glob_cnt_o} == {1'b0, $past(glob_cnt_o)} + 1'b1));

  assert_first_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_vld_o && !first_clr_i && !seq_start_i) |=> (first_vld_o && $stable(first_idx_o)));

  assert_trig_with_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> first_vld_o);

  assert_stop_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_req_o) |-> $past(stop_en_i));

  assert_start_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_i |=> (glob_cnt_o == '0 && !first_vld_o && byte_err_o == '0 && !stop_req_o));

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !seq_start_i) |=> $stable(glob_cnt_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R10: assert (glob_cnt_o == '0 && bit_err_o == '0 && !first_vld_o && !trig_o);
    end
  end
endmodule

bind readback_checker rbc_chk #(
  .NUM_LANES (NUM_LANES),
  .LANE_W    (LANE_W),
  .CNT_W     (CNT_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .seq_start_i (seq_start_i),
  .vld_i       (vld_i),
  .mask_i      (mask_i),
  .bit_clr_i   (bit_clr_i),
  .byte_clr_i  (byte_clr_i),
  .first_clr_i (first_clr_i),
  .stop_en_i   (stop_en_i),
  .bit_err_o   (bit_err_o),
  .byte_err_o  (byte_err_o),
  .lane_cnt_o  (lane_cnt_o),
  .glob_cnt_o  (glob_cnt_o),
  .first_vld_o (first_vld_o),
  .first_idx_o (first_idx_o),
  .trig_o      (trig_o),
  .stop_req_o  (stop_req_o)
);

// File: tb/readback_checker_tb_top.sv
module readback_checker_tb_top;
  localparam int NL = 9;
  localparam int LW = 8;
  localparam int CW = 4;
  localparam int IW = 16;
  localparam int DW = NL * LW;
  localparam logic [DW-1:0] EXP = 72'hA5_0123_4567_89AB_CDEF;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  typedef struct packed {
    logic [DW-1:0] flip;
    logic [DW-1:0] mk;
    logic [DW-1:0] bits;
    logic [NL-1:0] bytes;
    logic [CW-1:0] glob;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{72'h0, 72'h0, 72'h0, 9'h000, 4'd0},
    '{72'h1, 72'h0, 72'h1, 9'h001, 4'd1},
    '{72'h80_0000_0000_0000_0000, 72'h80_0000_0000_0000_0000, 72'h1, 9'h001, 4'd1},
    '{72'h01_0000_0000_0400_0000, 72'h0, 72'h01_0000_0000_0400_0001, 9'h109, 4'd2},
    '{ONES, ONES, 72'h01_0000_0000_0400_0001, 9'h109, 4'd2},
    '{ONES, 72'h0, ONES, 9'h1FF, 4'd3}
  };

  logic clk = 0, rst_ni = 0;
  logic seq_start = 0, vld = 0, byte_clr = 0, first_clr = 0, stop_en = 0, trig_en = 0;
  logic [DW-1:0] rd = '0, ex = '0, mk = '0;
  logic [NL-1:0] bit_clr = '0;
  logic [DW-1:0] bit_err;
  logic [NL-1:0] byte_err;
  logic [NL*CW-1:0] lane_cnt;
  logic [CW-1:0] glob_cnt;
  logic first_vld, trig, stop_req;
  logic [IW-1:0] first_idx;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  readback_checker #(.NUM_LANES(NL), .LANE_W(LW), .CNT_W(CW), .IDX_W(IW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .seq_start_i(seq_start), .vld_i(vld),
    .rd_data_i(rd), .exp_data_i(ex), .mask_i(mk), .bit_clr_i(bit_clr),
    .byte_clr_i(byte_clr), .first_clr_i(first_clr), .stop_en_i(stop_en),
    .trig_en_i(trig_en), .bit_err_o(bit_err), .byte_err_o(byte_err),
    .lane_cnt_o(lane_cnt), .glob_cnt_o(glob_cnt), .first_vld_o(first_vld),
    .first_idx_o(first_idx), .trig_o(trig), .stop_req_o(stop_req));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  // drive at negedge, one clock edge, strobes released, outputs sampled at next negedge
  task automatic cyc(logic v, logic [DW-1:0] flip, logic [DW-1:0] m);
    vld = v; ex = EXP; rd = EXP ^ flip; mk = m;
    @(posedge clk); @(negedge clk);
    vld = 0; seq_start = 0; byte_clr = 0; first_clr = 0; bit_clr = '0;
  endtask

  function automatic logic [CW-1:0] lcnt(int l);
    return lane_cnt[l*CW +: CW];
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 glob", glob_cnt, 0);
    chk("R10 bits", bit_err, 0);
    chk("R10 first/trig/stop", {first_vld, trig, stop_req}, 0);
    rst_ni = 1;
    @(negedge clk);

    // R1 R2 R3 R5 R12 table walk
    foreach (ROWS[i]) begin
      cyc(1'b1, ROWS[i].flip, ROWS[i].mk);
      chk($sformatf("R1 row%0d bits", i), bit_err, ROWS[i].bits);
      chk($sformatf("R3 row%0d bytes", i), byte_err, ROWS[i].bytes);
      chk($sformatf("R5 row%0d glob", i), glob_cnt, ROWS[i].glob);
    end
    chk("R6 first idx after table", first_idx, 1);
    chk("R4 lane0 count", lcnt(0), 2);
    chk("R4 lane8 count", lcnt(8), 2);
    chk("R4 lane1 count", lcnt(1), 1);
    chk("R7 no trig when disabled", trig, 0);

    // R2 per-lane bit clear
    bit_clr = 9'h001;
    cyc(1'b0, 72'h0, 72'h0);
    chk("R2 lane0 cleared", bit_err[7:0], 0);
    chk("R2 other lanes kept", bit_err[DW-1:8], ONES[DW-1:8]);
    chk("R3 bytes unaffected by bit clear", byte_err, 9'h1FF);

    // R3 byte clear
    byte_clr = 1;
    cyc(1'b0, 72'h0, 72'h0);
    chk("R3 bytes cleared", byte_err, 0);
    chk("R3 bits unaffected", bit_err[DW-1:8], ONES[DW-1:8]);

    // R11 idle with mismatching data
    cyc(1'b0, ONES, 72'h0);
    chk("R11 glob unchanged", glob_cnt, 3);
    chk("R11 bytes unchanged", byte_err, 0);

    // R2 set wins over clear
    bit_clr = 9'h002;
    cyc(1'b1, 72'h800, 72'h0);
    chk("R2 set wins lane1", bit_err[15:8], 8'h08);
    chk("R3 lane1 flag", byte_err, 9'h002);
    chk("R5 glob 4", glob_cnt, 4);
    chk("R6 first held", first_idx, 1);

    // R8 stop request
    stop_en = 1;
    cyc(1'b1, 72'h1, 72'h0);
    chk("R8 stop set", stop_req, 1);
    stop_en = 0;
    cyc(1'b1, 72'h0, 72'h0);
    chk("R8 stop held", stop_req, 1);

    // R9 start with a failing vector
    seq_start = 1;
    cyc(1'b1, ONES, 72'h0);
    chk("R9 glob zero", glob_cnt, 0);
    chk("R9 bits zero", bit_err, 0);
    chk("R9 first/stop zero", {first_vld, stop_req}, 0);

    // R6 R7 first capture and trigger
    trig_en = 1;
    cyc(1'b1, 72'h1, 72'h0);
    chk("R7 trig pulse", trig, 1);
    chk("R6 first at 0", {first_vld, first_idx}, {1'b1, 16'd0});
    cyc(1'b1, 72'h1, 72'h0);
    chk("R7 trig one cycle", trig, 0);
    chk("R6 first kept", first_idx, 0);
    cyc(1'b1, 72'h0, 72'h0);
    first_clr = 1;
    cyc(1'b1, 72'h1, 72'h0);
    chk("R6 recapture at 3", {first_vld, first_idx}, {1'b1, 16'd3});
    chk("R7 trig on recapture", trig, 1);
    first_clr = 1;
    cyc(1'b0, 72'h0, 72'h0);
    chk("R6 released", first_vld, 0);
    trig_en = 0;

    // R4 R5 saturation
    seq_start = 1;
    cyc(1'b0, 72'h0, 72'h0);
    for (int n = 0; n < 20; n++) cyc(1'b1, 72'h1_0000, 72'h0);
    chk("R4 lane2 saturated", lcnt(2), 4'hF);
    chk("R5 glob saturated", glob_cnt, 4'hF);
    chk("R4 lane0 zero", lcnt(0), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule